// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This is a DSP arithmetic block that multiplies signed 16-bit halves picked out of 32-bit operands. A 2-bit mode input selects one of four operations. The first is a plain 16×16 product. The second is a 16×16 product added into a 64-bit accumulator that arrives as a high/low word pair. The third is a 32×16 product scaled down by 2^16. The fourth is that same scaled product added to a 32-bit accumulator.

An operation is launched with a one-cycle start strobe. One clock later the unit presents the result in a single output register, together with a one-cycle done pulse. The 32-bit accumulate reports signed overflow on a set pulse, which the surrounding core ORs into its sticky saturation flag. That result still wraps; it is not clamped. The 64-bit accumulate wraps silently.

Top module: `hmac_unit`

## Requirements
- R1: While rst_ni is low, and after it is released until the first start, done_o, sat_set_o, res_lo_o and res_hi_o are all zero.
- R2: When start_i is high at a rising edge, done_o is high for exactly the following cycle and the results of that operation appear in the same cycle. With start_i low, done_o stays low and res_lo_o, res_hi_o keep their values whatever the other inputs do.
- R3: Half selection works the same way for each multiply. When sel_a_hi_i is 1 the unit uses op_a_i[31:16], and when it is 0 it uses op_a_i[15:0]. sel_b_hi_i picks the half of op_b_i in the same way. Each chosen half is sign-extended from its bit 15.
- R4: Mode 2'b00 (16×16 multiply) gives res_lo_o equal to the full signed 32-bit product of the two selected halves, with res_hi_o = 0.
- R5: Mode 2'b01 (long accumulate) gives {res_hi_o, res_lo_o} = {acc_hi_i, acc_lo_i} plus the sign-extended 16×16 product, modulo 2^64. sat_set_o stays 0 in this mode.
- R6: Mode 2'b10 (wide multiply) gives res_lo_o equal to bits [47:16] of the signed 48-bit product of the whole op_a_i and the selected half of op_b_i. sel_a_hi_i has no effect, and res_hi_o = 0.
- R7: Mode 2'b11 (wide accumulate) gives res_lo_o = (wide result + acc_lo_i) mod 2^32, with res_hi_o = 0. sat_set_o is high together with done_o exactly when that signed 32-bit addition overflows.
- R8: sat_set_o is never high without done_o, and never high for modes 2'b00, 2'b01 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe; samples all operands |
| mode_i | input | 2 | 00 mul16, 01 long acc, 10 wide, 11 wide acc |
| sel_a_hi_i | input | 1 | Pick upper half of op_a_i |
| sel_b_hi_i | input | 1 | Pick upper half of op_b_i |
| op_a_i | input | 32 | First source operand |
| op_b_i | input | 32 | Second source operand |
| acc_lo_i | input | 32 | Low accumulator word / 32-bit accumulator |
| acc_hi_i | input | 32 | High accumulator word |
| res_lo_o | output | 32 | Result, low word |
| res_hi_o | output | 32 | Result, high word (long mode only) |
| done_o | output | 1 | Result valid pulse |
| sat_set_o | output | 1 | Sticky saturation set pulse |

## Verification
The hardest case to reach is the overflow report in wide accumulate, because a 32×16 product scaled by 2^16 never exceeds 2^30 in magnitude. Overflow therefore needs both the product and the accumulator near an extreme of the same sign. The stimulus builds this directly. It uses op_a_i = 0x80000000 against a selected half of 0x8000, which gives +2^30, together with an accumulator of 0x40000000. It also uses op_a_i = 0x80000000 against 0x7FFF with an accumulator of 0x80000000 for the negative case. Random operations mixed with forced ±0x8000 halves then cover the remaining modes and carry paths.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  typedef enum logic [1:0] {
    MODE_MUL16    = 2'b00,
    MODE_LONG     = 2'b01,
    MODE_WIDE     = 2'b10,
    MODE_WIDE_ACC = 2'b11
  } hmac_mode_e;
endpackage

// File: rtl/hmac_half_pick.sv
module hmac_half_pick #(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic [DW-1:0]        word_i,
  input  logic                 hi_i,
  output logic signed [HW-1:0] half_o
);
  assign half_o = hi_i ? $signed(word_i[DW-1:HW]) : $signed(word_i[HW-1:0]);
endmodule

// File: rtl/hmac_mult.sv
module hmac_mult #(
  parameter int DW = 32,
  localparam int HW = DW / 2,
  localparam int PW = DW + HW
) (
  input  logic signed [HW-1:0] a_half_i,
  input  logic signed [HW-1:0] b_half_i,
  input  logic [DW-1:0]        a_word_i,
  output logic signed [DW-1:0] half_prod_o,
  output logic signed [DW-1:0] wide_prod_o
);
  logic signed [PW-1:0] wprod;
  logic                 unused_low;

  assign half_prod_o = a_half_i * b_half_i;
  assign wprod       = $signed(a_word_i) * b_half_i;
  // keep product bits [PW-1:HW]; the low half is discarded
  assign wide_prod_o = wprod[PW-1:HW];
  assign unused_low  = ^wprod[HW-1:0];
endmodule

// File: rtl/hmac_accum.sv
module hmac_accum
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  hmac_mode_e           mode_i,
  input  logic signed [DW-1:0] half_prod_i,
  input  logic signed [DW-1:0] wide_prod_i,
  input  logic [DW-1:0]        acc_lo_i,
  input  logic [DW-1:0]        acc_hi_i,
  output logic [DW-1:0]        res_lo_o,
  output logic [DW-1:0]        res_hi_o,
  output logic                 ovf_o
);
  logic [2*DW-1:0] long_sum;
  logic [DW-1:0]   short_sum;

  assign long_sum  = {acc_hi_i, acc_lo_i} + {{DW{half_prod_i[DW-1]}}, half_prod_i};
  assign short_sum = wide_prod_i + acc_lo_i;

  always_comb begin
    res_lo_o = '0;
    res_hi_o = '0;
    ovf_o    = 1'b0;
    unique case (mode_i)
      MODE_MUL16: res_lo_o = half_prod_i;
      MODE_LONG: begin
        res_lo_o = long_sum[DW-1:0];
        res_hi_o = long_sum[2*DW-1:DW];
      end
      MODE_WIDE: res_lo_o = wide_prod_i;
      MODE_WIDE_ACC: begin
        res_lo_o = short_sum;
        // same-sign operands giving a result of the other sign
        ovf_o    = (wide_prod_i[DW-1] == acc_lo_i[DW-1]) &&
                   (short_sum[DW-1] != acc_lo_i[DW-1]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          sel_a_hi_i,
  input  logic          sel_b_hi_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic [DW-1:0] acc_lo_i,
  input  logic [DW-1:0] acc_hi_i,
  output logic [DW-1:0] res_lo_o,
  output logic [DW-1:0] res_hi_o,
  output logic          done_o,
  output logic          sat_set_o
);
  hmac_mode_e           mode;
  logic signed [HW-1:0] a_half, b_half;
  logic signed [DW-1:0] half_prod, wide_prod;
  logic [DW-1:0]        nxt_lo, nxt_hi;
  logic                 nxt_ovf;

  assign mode = hmac_mode_e'(mode_i);

  hmac_half_pick #(.DW(DW)) i_pick_a (
    .word_i(op_a_i), .hi_i(sel_a_hi_i), .half_o(a_half)
  );
  hmac_half_pick #(.DW(DW)) i_pick_b (
    .word_i(op_b_i), .hi_i(sel_b_hi_i), .half_o(b_half)
  );

  hmac_mult #(.DW(DW)) i_mult (
    .a_half_i    (a_half),
    .b_half_i    (b_half),
    .a_word_i    (op_a_i),
    .half_prod_o (half_prod),
    .wide_prod_o (wide_prod)
  );

  hmac_accum #(.DW(DW)) i_accum (
    .mode_i      (mode),
    .half_prod_i (half_prod),
    .wide_prod_i (wide_prod),
    .acc_lo_i    (acc_lo_i),
    .acc_hi_i    (acc_hi_i),
    .res_lo_o    (nxt_lo),
    .res_hi_o    (nxt_hi),
    .ovf_o       (nxt_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_lo_o  <= '0;
      res_hi_o  <= '0;
      done_o    <= 1'b0;
      sat_set_o <= 1'b0;
    end else begin
      done_o    <= start_i;
      sat_set_o <= start_i && nxt_ovf;
      if (start_i) begin
        res_lo_o <= nxt_lo;
        res_hi_o <= nxt_hi;
      end
    end
  end
endmodule

// File: rtl/hmac_checker.sv
module hmac_checker #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] res_lo_o,
  input logic [DW-1:0] res_hi_o,
  input logic          done_o,
  input logic          sat_set_o
);
  assert_done_follows_start_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni) start_i |=> done_o);

  assert_no_done_idle_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !start_i |=> !done_o);

  assert_hold_when_idle_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(res_lo_o) && $stable(res_hi_o)));

  assert_hi_zero_short_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i != 2'b01) |=> res_hi_o == '0);

  assert_sat_with_done_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni) sat_set_o |-> done_o);

  assert_sat_mode_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i != 2'b11) |=> !sat_set_o);
endmodule

bind hmac_unit hmac_checker #(.DW(DW)) i_hmac_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .res_lo_o  (res_lo_o),
  .res_hi_o  (res_hi_o),
  .done_o    (done_o),
  .sat_set_o (sat_set_o)
);

// File: tb/test_hmac_unit.sv
module test_hmac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic        sel_a = 1'b0, sel_b = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
  logic [31:0] res_lo, res_hi;
  logic        done, sat_set;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] q_lo[$];
  logic [31:0] q_hi[$];
  logic        q_sat[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hmac_unit i_hmac_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .sel_a_hi_i(sel_a), .sel_b_hi_i(sel_b), .op_a_i(op_a), .op_b_i(op_b),
    .acc_lo_i(acc_lo), .acc_hi_i(acc_hi), .res_lo_o(res_lo), .res_hi_o(res_hi),
    .done_o(done), .sat_set_o(sat_set)
  );

  function automatic longint sx16(input logic [15:0] h);
    return {{48{h[15]}}, h};
  endfunction

  function automatic longint sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // 64-bit signed reference model
  task automatic model(input logic [1:0] m, input logic sa, input logic sb,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] al, input logic [31:0] ah,
                       output logic [31:0] lo, output logic [31:0] hi,
                       output logic sat);
    longint ha, hb, p, w, s, acc;
    ha  = sa ? sx16(a[31:16]) : sx16(a[15:0]);
    hb  = sb ? sx16(b[31:16]) : sx16(b[15:0]);
    p   = ha * hb;
    w   = (sx32(a) * hb) >>> 16;
    lo  = '0; hi = '0; sat = 1'b0;
    case (m)
      2'b00: lo = p[31:0];
      2'b01: begin
        acc = {ah, al};
        acc = acc + p;
        lo  = acc[31:0];
        hi  = acc[63:32];
      end
      2'b10: lo = w[31:0];
      default: begin
        s   = w + sx32(al);
        lo  = s[31:0];
        sat = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
    endcase
  endtask

  task automatic run_op(input logic [1:0] m, input logic sa, input logic sb,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] al, input logic [31:0] ah,
                        input string tag);
    logic [31:0] elo, ehi;
    logic esat;
    model(m, sa, sb, a, b, al, ah, elo, ehi, esat);
    @(negedge clk);
    mode = m; sel_a = sa; sel_b = sb;
    op_a = a; op_b = b; acc_lo = al; acc_hi = ah;
    start = 1'b1;
    q_lo.push_back(elo); q_hi.push_back(ehi);
    q_sat.push_back(esat); q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: pop expected item on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      total++;
      if (q_lo.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected done: actual=1 expected=0");
      end else begin
        logic [31:0] elo, ehi;
        logic esat;
        string tag;
        elo = q_lo.pop_front(); ehi = q_hi.pop_front();
        esat = q_sat.pop_front(); tag = q_tag.pop_front();
        if (res_lo !== elo || res_hi !== ehi || sat_set !== esat) begin
          bad++;
          $display("FAIL %s: actual lo=%h hi=%h sat=%b expected lo=%h hi=%h sat=%b",
                   tag, res_lo, res_hi, sat_set, elo, ehi, esat);
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_lo, hold_hi;
    repeat (3) @(negedge clk);
    check(done === 0 && sat_set === 0 && res_lo === 0 && res_hi === 0,
          $sformatf("R1 in reset: actual %h/%h/%b/%b expected zeros", res_lo, res_hi, done, sat_set));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done === 0 && sat_set === 0 && res_lo === 0 && res_hi === 0,
          $sformatf("R1 after release: actual %h/%h/%b/%b expected zeros", res_lo, res_hi, done, sat_set));

    // R3/R4 half selection and 16x16 extremes
    run_op(2'b00, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 0, 0, "R4 -0x8000^2");
    run_op(2'b00, 1'b1, 1'b0, 32'h7FFF_0003, 32'h1234_8000, 0, 0, "R3 hi a lo b");
    run_op(2'b00, 1'b0, 1'b1, 32'h7FFF_0003, 32'hFFFE_8000, 0, 0, "R3 lo a hi b");
    run_op(2'b00, 1'b1, 1'b1, 32'h8000_0001, 32'h7FFF_0001, 0, 0, "R3 hi a hi b");
    // R5 long accumulate, wrap, no sat
    run_op(2'b01, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 wrap to zero");
    run_op(2'b01, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'hC000_0000, 32'h7FFF_FFFF, "R5 carry into hi");
    run_op(2'b01, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_7FFF, 32'h0000_0000, 32'h0000_0000, "R5 borrow from hi");
    // R6 wide, sel_a ignored
    run_op(2'b10, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 0, 0, "R6 extreme");
    run_op(2'b10, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000, 0, 0, "R6 sel_a ignored");
    run_op(2'b10, 1'b1, 1'b1, 32'h1234_5678, 32'h8000_1111, 0, 0, "R6 hi b");
    // R7 wide accumulate overflow both directions
    run_op(2'b11, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 0, "R7 positive overflow");
    run_op(2'b11, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 0, "R7 negative overflow");
    run_op(2'b11, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h3FFF_FFFF, 0, "R7 edge no overflow");
    // R8 large values in non-accumulating modes give no sat
    run_op(2'b10, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 0, "R8 wide no sat");
    run_op(2'b01, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R8 long no sat");
    @(negedge clk);

    // R2 hold: idle cycles with changing inputs
    hold_lo = res_lo; hold_hi = res_hi;
    for (int i = 0; i < 3; i++) begin
      op_a = $urandom; op_b = $urandom; acc_lo = $urandom; mode = 2'(i);
      @(negedge clk);
      check(done === 0 && res_lo === hold_lo && res_hi === hold_hi,
            $sformatf("R2 hold: actual %h/%h/%b expected %h/%h/0", res_lo, res_hi, done, hold_lo, hold_hi));
    end

    // random mix with forced extremes
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b, al, ah;
      a = $urandom; b = $urandom; al = $urandom; ah = $urandom;
      if (i % 4 == 0) a[15:0] = 16'h8000;
      if (i % 5 == 0) b[31:16] = 16'h8000;
      if (i % 7 == 0) a = 32'h8000_0000;
      run_op(2'(i % 4), 1'($urandom), 1'($urandom), a, b, al, ah, "R3-mix random");
    end
    repeat (3) @(negedge clk);
    check(q_lo.size() == 0, $sformatf("R2 missing done: actual pending=%0d expected=0", q_lo.size()));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule